// File: doc/BRIEF.md
# Key-Protected Scratch RAM

This block is a small byte-wide scratch memory that sits on a CPU bus inside a cartridge-style banking controller. It holds 128 bytes that the CPU reaches in the window $7F00-$7F7F. Before decoding, the address is ANDed with $FF7F, so address bit 7 is ignored. As a result, $7F80-$7FFF reach the same 128 bytes.

Access is guarded by a lock. A write of the exact byte $A3 to the unlock register at $7E78 or $7E79 opens the memory for both reads and writes. A write of any other byte to that register closes it again. While the memory is locked, writes to it are dropped. Reads return nothing: the valid flag stays low, and the surrounding bus sees open bus.

Read data is registered. It appears together with the valid flag one clock after the read strobe.

Top module: `keyed_scratch_ram`

## Requirements
- R1: After reset the memory is locked, and rdValid is low with rdData zero.
- R2: A write of $A3 to an address that masks to $7E78 or $7E79 unlocks the memory from the next clock on. This includes $7EF8 and $7EF9.
- R3: A write of any byte other than $A3 to the unlock register locks the memory from the next clock on.
- R4: While unlocked, a write to $7F00-$7F7F stores the data byte at index address[6:0].
- R5: While locked, a write to the memory window leaves the stored byte unchanged.
- R6: While unlocked, a read of the memory window raises rdValid in the following cycle, with rdData equal to the byte stored at address[6:0].
- R7: In a cycle that does not follow an unlocked in-window read, rdValid is low and rdData is zero. This covers reads while locked and reads outside the window.
- R8: Addresses $7F80-$7FFF reach the same bytes as $7F00-$7F7F, for both reads and writes.
- R9: Writes to addresses outside the window and outside the unlock register, such as $7E70, $FF00 or $6F00, change neither the lock nor the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuRd | input | 1 | Read strobe, one cycle per access |
| cpuWr | input | 1 | Write strobe, one cycle per access |
| rdData | output | 8 | Registered read data, zero when not valid |
| rdValid | output | 1 | High when rdData drives the bus |

## Verification
The bench keeps a behavioural model of the lock and the 128 bytes and compares rdValid and rdData with it on every clock. It first runs locked reads and locked writes. It then unlocks and writes a distinct pattern to every index, which tells apart a correct index decode from a dropped or swapped address bit. Mirror-window accesses are mixed with base-window accesses, which exposes a wrong decode mask. Alternating lock and unlock writes with near-miss key bytes, and with near-miss register addresses, separate exact key matching from partial matching.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ramStrobe_t;
endpackage

// File: rtl/scratch_ctrl.sv
module scratch_ctrl
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_DEPTH = 128,
  parameter logic [ADDR_W-1:0] DECODE_MASK = 16'hFF7F,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h7F00,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'h7E78,
  parameter logic [DATA_W-1:0] KEY_VALUE = 8'hA3,
  localparam int IDX_W = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRd,
  input  logic              cpuWr,
  output ramStrobe_t        strobes,
  output logic [IDX_W-1:0]  ramIdx
);
  localparam logic [ADDR_W-1:0] RAM_SPAN_MASK = ~ADDR_W'(RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] KEY_SPAN_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] maskedAddr;
  logic ramHit, keyHit, unlocked;

  assign maskedAddr = cpuAddr & DECODE_MASK;
  assign ramHit = (maskedAddr & RAM_SPAN_MASK) == RAM_BASE;
  assign keyHit = (maskedAddr & KEY_SPAN_MASK) == KEY_BASE;
  assign ramIdx = cpuAddr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (cpuWr && keyHit) unlocked <= (cpuWrData == KEY_VALUE);
  end

  always_comb begin
    strobes.wrEn = cpuWr && ramHit && unlocked;
    strobes.rdEn = cpuRd && ramHit && unlocked;
  end

  // R3
  key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWr && keyHit && cpuWrData != KEY_VALUE) |=> !unlocked);

  // R2
  key_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWr && keyHit && cpuWrData == KEY_VALUE) |=> unlocked);

  // R5
  locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !strobes.wrEn);
endmodule

// File: rtl/scratch_datapath.sv
module scratch_datapath
  import scratch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RAM_DEPTH = 128,
  localparam int IDX_W = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ramStrobe_t        strobes,
  input  logic [IDX_W-1:0]  ramIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] store [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[ramIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else if (strobes.rdEn) begin
      rdValid <= 1'b1;
      rdData  <= store[ramIdx];
    end else begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end
  end

  // R6
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdEn |=> rdValid);

  // R7
  no_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.rdEn |=> (!rdValid && rdData == '0));
endmodule

// File: rtl/keyed_scratch_ram.sv
module keyed_scratch_ram
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_DEPTH = 128,
  parameter logic [ADDR_W-1:0] DECODE_MASK = 16'hFF7F,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h7F00,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'h7E78,
  parameter logic [DATA_W-1:0] KEY_VALUE = 8'hA3,
  localparam int IDX_W = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRd,
  input  logic              cpuWr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  ramStrobe_t strobes;
  logic [IDX_W-1:0] ramIdx;

  scratch_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH),
    .DECODE_MASK(DECODE_MASK), .RAM_BASE(RAM_BASE),
    .KEY_BASE(KEY_BASE), .KEY_VALUE(KEY_VALUE)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .strobes(strobes), .ramIdx(ramIdx)
  );

  scratch_datapath #(
    .DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH)
  ) i_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .ramIdx(ramIdx),
    .wrData(cpuWrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/test_keyed_scratch_ram.sv
module test_keyed_scratch_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0;
  logic [7:0] rdData;
  logic rdValid;

  int checks = 0, fails = 0;
  string curReq = "R1";
  bit done = 0;

  // reference model
  int model [128];
  bit modelOpen = 0;
  bit expValid = 0;
  int expData = 0;

  always #2.5 clk = ~clk;

  keyed_scratch_ram i_keyed_scratch_ram (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .rdData(rdData), .rdValid(rdValid)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modelOpen = 0; expValid = 0; expData = 0;
    end else begin
      int a;
      bit inWin, isKey;
      a = cpuAddr & 16'hFF7F;
      inWin = (a >= 16'h7F00) && (a <= 16'h7F7F);
      isKey = (a == 16'h7E78) || (a == 16'h7E79);
      if (cpuRd && inWin && modelOpen) begin
        expValid = 1; expData = model[a % 128];
      end else begin
        expValid = 0; expData = 0;
      end
      if (cpuWr && inWin && modelOpen) model[a % 128] = cpuWrData;
      if (cpuWr && isKey) modelOpen = (cpuWrData == 8'hA3);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rdValid !== expValid || int'(rdData) !== expData) begin
        fails++;
        $display("FAIL %s: rdValid=%0b rdData=%02h expected rdValid=%0b rdData=%02h",
                 curReq, rdValid, rdData, expValid, expData[7:0]);
      end
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWr = w; cpuRd = r; cpuAddr = a; cpuWrData = d;
  endtask

  task automatic idle();
    cyc(0, 0, 16'h0000, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    curReq = "R1"; idle(); idle();
    curReq = "R7"; cyc(0, 1, 16'h7F10, 0); idle();
    curReq = "R5"; cyc(1, 0, 16'h7F10, 8'h55); idle();
    curReq = "R2"; cyc(1, 0, 16'h7E78, 8'hA3); cyc(0, 1, 16'h7F10, 0); idle();
    curReq = "R4";
    for (int i = 0; i < 128; i++) cyc(1, 0, 16'h7F00 + 16'(i), 8'(i ^ 8'h5A));
    curReq = "R6";
    for (int i = 0; i < 128; i++) cyc(0, 1, 16'h7F00 + 16'(i), 0);
    idle();
    curReq = "R8";
    cyc(1, 0, 16'h7F85, 8'hC3); cyc(0, 1, 16'h7F05, 0);
    cyc(1, 0, 16'h7F22, 8'h3C); cyc(0, 1, 16'h7FA2, 0);
    cyc(0, 1, 16'h7FFF, 0); idle();
    curReq = "R9";
    cyc(1, 0, 16'h7E70, 8'h00); cyc(1, 0, 16'hFF00, 8'hEE); cyc(1, 0, 16'h6F00, 8'hEE);
    cyc(1, 0, 16'h7E7A, 8'h00);
    cyc(0, 1, 16'h7F00, 0); cyc(0, 1, 16'hFF00, 0); cyc(0, 1, 16'h7E78, 0); idle();
    curReq = "R3";
    cyc(1, 0, 16'h7E79, 8'hA2); cyc(0, 1, 16'h7F05, 0); idle();
    curReq = "R5";
    cyc(1, 0, 16'h7F05, 8'h11); cyc(1, 0, 16'h7F06, 8'h22);
    curReq = "R2";
    cyc(1, 0, 16'h7EF9, 8'hA3); cyc(0, 1, 16'h7F05, 0); cyc(0, 1, 16'h7F06, 0);
    curReq = "R3";
    cyc(1, 0, 16'h7EF8, 8'h23); cyc(0, 1, 16'h7F06, 0);
    curReq = "R9";
    cyc(1, 0, 16'h7E7A, 8'hA3); cyc(0, 1, 16'h7F06, 0);
    curReq = "R2";
    cyc(1, 0, 16'h7E78, 8'hA3); cyc(0, 1, 16'h7F06, 0);
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule